// File: doc/BRIEF.md
# Chained DMA Descriptor Walker

This block drives command chaining for a DMA transfer engine. Software sets a table address and pulses `go`. The walker then reads a descriptor from local memory one 32-bit word at a time over a simple request/acknowledge read port. It loads the descriptor's transfer fields into the execution registers that face the engine, pulses `eng_start`, and waits for the engine to report success or failure. If the descriptor's link word does not mark the end of the list, the walker follows the link to the next descriptor.

When chaining is off, `go` runs the directly programmed register set once and then reports completion. Interrupt events come from three sources: an entry whose control word asks for one, the normal end of the whole request, and any error. Each event becomes a one-cycle `irq` pulse, but only while `irq_en` is high. An error from the engine or from a memory read stops the walk at once and sets a sticky error flag.

Top module: `dma_chain_walker`

## Requirements
- R1: After synchronous reset, `busy`, `mem_req`, `eng_start`, `irq` and `err_sticky` are all 0.
- R2: When `go` is accepted with `chain_en`=0, exactly one transfer runs, using the `dir_*` values presented on `eng_*`. No memory read is made, and the request then completes.
- R3: When `go` is accepted with `chain_en`=1, the walker reads five words at `table_addr`+0, +4, +8, +12 and +16, in that order. It holds `mem_req` and `mem_addr` until `mem_ack`. The words are, in order: remote address, local address, byte count, control word, link word.
- R4: Link word bit 0 = 1 ends the list. Otherwise the next descriptor starts at the link word with bits [1:0] cleared. Transfers run in list order.
- R5: Control word bit 0 = 1 raises an interrupt event when that entry's transfer reports done.
- R6: Normal completion always raises an interrupt event. Normal completion means the last entry is done, or the direct transfer is done. When it falls in the same cycle as an entry event, the two give a single pulse.
- R7: An event appears on `irq` as a pulse one clock wide, one cycle after the event, and only when `irq_en` is 1.
- R8: `eng_err` aborts the request, and it wins over `eng_done`. No further word is fetched, `busy` falls, `err_sticky` is set and an event is raised.
- R9: `mem_err` on a read beat aborts the request. No further read is made, no transfer starts for that descriptor, `err_sticky` is set and an event is raised.
- R10: `go` while `busy` is ignored. `err_sticky` is cleared only by reset or by an accepted `go`.
- R11: `eng_start` is high for exactly one cycle per transfer. The `eng_*` fields stay unchanged from the start until the engine reports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start request, accepted only when idle |
| chain_en | input | 1 | 1: walk the descriptor list; 0: run the direct registers once |
| irq_en | input | 1 | Interrupt output enable |
| table_addr | input | 32 | Address of the first descriptor |
| dir_rmt_addr | input | 32 | Direct remote-bus address |
| dir_loc_addr | input | 32 | Direct local-bus address |
| dir_nbytes | input | 32 | Direct byte count |
| dir_ctrl | input | 32 | Direct control word |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_ack | input | 1 | Read beat complete |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Read failed, valid with `mem_ack` |
| eng_start | output | 1 | One-cycle transfer start |
| eng_rmt_addr | output | 32 | Remote-bus address for the engine |
| eng_loc_addr | output | 32 | Local-bus address for the engine |
| eng_nbytes | output | 32 | Byte count for the engine |
| eng_ctrl | output | 32 | Control word for the engine |
| eng_done | input | 1 | Engine finished the transfer |
| eng_err | input | 1 | Engine failed the transfer |
| busy | output | 1 | Request in progress |
| err_sticky | output | 1 | An error ended the last request |
| irq | output | 1 | Gated interrupt pulse |

## Verification
Suppose the walker holds a wrong word index or a wrong table pointer. Then the fetch addresses or the loaded fields differ on the very next read beat or the next `eng_start`, so a wrong address shows within one descriptor. A wrong end-of-list decision or a wrong abort decision shows as a transfer count off by one, or as a missing or extra `irq` pulse, by the time `busy` falls. A flaw in the event merging shows in the pulse count of a single request. The bench therefore records every read address, every start and every pulse, and compares them with the values that follow from the list it built.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

    localparam int DW         = 32;
    localparam int DESC_WORDS = 5;
    localparam int IDX_W      = $clog2(DESC_WORDS + 1);
    localparam int WORD_BYTES = DW / 8;
    localparam int BYTE_SH    = $clog2(WORD_BYTES);
    localparam int CTRL_IRQ_BIT = 0;
    localparam int LINK_END_BIT = 0;

    typedef logic [DW-1:0] word_t;

    // transfer fields handed to the engine, in descriptor word order
    typedef struct packed {
        word_t rmt_addr;
        word_t loc_addr;
        word_t nbytes;
        word_t ctrl;
    } xfer_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_START,
        ST_WAIT
    } walk_st_t;

    function automatic word_t link_addr(word_t w);
        return w & ~word_t'(WORD_BYTES - 1);
    endfunction

    function automatic logic link_end(word_t w);
        return w[LINK_END_BIT];
    endfunction

endpackage

// File: rtl/dcw_fetch.sv
module dcw_fetch
    import dcw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  word_t base,
    output logic  mem_req,
    output word_t mem_addr,
    input  logic  mem_ack,
    input  word_t mem_rdata,
    input  logic  mem_err,
    output logic  done,
    output logic  err,
    output xfer_t xfer,
    output word_t link
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

    logic             active;
    logic [IDX_W-1:0] idx;
    word_t            base_q;
    logic             beat;

    assign beat = active & mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
            base_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            idx    <= '0;
            base_q <= base;
        end else if (beat) begin
            idx <= idx + 1'b1;
            if (mem_err || idx == LAST_IDX) begin
                active <= 1'b0;
            end
        end
    end

    // capture registers for every word except the link, which is used as it arrives
    for (genvar g = 0; g < DESC_WORDS - 1; g++) begin : g_cap
        word_t w_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                w_q <= '0;
            end else if (beat && idx == IDX_W'(g)) begin
                w_q <= mem_rdata;
            end
        end
    end

    assign mem_req  = active;
    assign mem_addr = base_q + (word_t'(idx) << BYTE_SH);
    assign done     = beat & ~mem_err & (idx == LAST_IDX);
    assign err      = beat & mem_err;
    assign link     = mem_rdata;

    assign xfer = '{
        rmt_addr: g_cap[0].w_q,
        loc_addr: g_cap[1].w_q,
        nbytes:   g_cap[2].w_q,
        ctrl:     g_cap[3].w_q
    };

    // R3: a pending read keeps its address until acknowledged
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R3: a good beat inside a descriptor moves to the following word
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && !mem_err && idx != LAST_IDX
        |=> mem_req && mem_addr == $past(mem_addr) + word_t'(WORD_BYTES));

    // R9: a failed beat ends the read sequence
    a_r9_stop: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && mem_err |=> !mem_req);

endmodule

// File: rtl/dcw_ctl.sv
module dcw_ctl
    import dcw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  go,
    input  logic  chain_en,
    input  word_t table_addr,
    input  xfer_t direct,
    input  logic  fetch_done,
    input  logic  fetch_err,
    input  xfer_t fetched,
    input  word_t link,
    input  logic  eng_done,
    input  logic  eng_err,
    output logic  fetch_start,
    output word_t fetch_base,
    output logic  eng_start,
    output xfer_t exec,
    output logic  busy,
    output logic  err_sticky,
    output logic  evt
);

    walk_st_t state_q;
    logic     chain_q;
    word_t    link_q;
    xfer_t    exec_q;
    logic     err_q;

    logic accept;
    logic fin_ok;
    logic fin_bad;
    logic more;

    assign accept  = (state_q == ST_IDLE) && go;
    assign fin_bad = (state_q == ST_WAIT) && eng_err;
    assign fin_ok  = (state_q == ST_WAIT) && eng_done && !eng_err;
    assign more    = fin_ok && chain_q && !link_end(link_q);

    assign fetch_start = (accept && chain_en) || more;
    assign fetch_base  = accept ? table_addr : link_addr(link_q);

    assign evt = fin_bad
              || ((state_q == ST_FETCH) && fetch_err)
              || (fin_ok && (exec_q.ctrl[CTRL_IRQ_BIT] || !more));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            chain_q <= 1'b0;
            link_q  <= '0;
            exec_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (go) begin
                        err_q   <= 1'b0;
                        chain_q <= chain_en;
                        if (chain_en) begin
                            state_q <= ST_FETCH;
                        end else begin
                            exec_q  <= direct;
                            state_q <= ST_START;
                        end
                    end
                end
                ST_FETCH: begin
                    if (fetch_err) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (fetch_done) begin
                        exec_q  <= fetched;
                        link_q  <= link;
                        state_q <= ST_START;
                    end
                end
                ST_START: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (eng_err) begin
                        err_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (eng_done) begin
                        state_q <= more ? ST_FETCH : ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign eng_start  = (state_q == ST_START);
    assign exec       = exec_q;
    assign busy       = (state_q != ST_IDLE);
    assign err_sticky = err_q;

    // R11: start is a single-cycle pulse
    a_r11_pulse: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R11: fields presented to the engine do not move while it runs
    a_r11_stable: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> $stable(exec));

    // R8: an engine error ends the request with the flag set
    a_r8_abort: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT) && eng_err |=> !busy && err_sticky && !fetch_start);

    // R6: every way out of a request carries an interrupt event
    a_r6_end_evt: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(evt));

    // R10: a go during a request leaves the error flag alone
    a_r10_busy_go: assert property (@(posedge clk) disable iff (rst)
        busy && go && !fetch_err && !eng_err |=> $stable(err_sticky));

endmodule

// File: rtl/dcw_irq.sv
module dcw_irq (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic en,
    output logic irq
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= evt & en;
        end
    end

    assign irq = irq_q;

    // R7: a pulse only follows a cycle in which the enable was set
    a_r7_gate: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(en));

endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
    import dcw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        go,
    input  logic        chain_en,
    input  logic        irq_en,
    input  logic [31:0] table_addr,
    input  logic [31:0] dir_rmt_addr,
    input  logic [31:0] dir_loc_addr,
    input  logic [31:0] dir_nbytes,
    input  logic [31:0] dir_ctrl,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    input  logic        mem_err,
    output logic        eng_start,
    output logic [31:0] eng_rmt_addr,
    output logic [31:0] eng_loc_addr,
    output logic [31:0] eng_nbytes,
    output logic [31:0] eng_ctrl,
    input  logic        eng_done,
    input  logic        eng_err,
    output logic        busy,
    output logic        err_sticky,
    output logic        irq
);

    xfer_t direct;
    xfer_t fetched;
    xfer_t exec;
    word_t link;
    word_t fetch_base;
    logic  fetch_start;
    logic  fetch_done;
    logic  fetch_err;
    logic  evt;

    assign direct = '{
        rmt_addr: dir_rmt_addr,
        loc_addr: dir_loc_addr,
        nbytes:   dir_nbytes,
        ctrl:     dir_ctrl
    };

    dcw_fetch i_fetch (
        .clk       (clk),
        .rst       (rst),
        .start     (fetch_start),
        .base      (fetch_base),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_err   (mem_err),
        .done      (fetch_done),
        .err       (fetch_err),
        .xfer      (fetched),
        .link      (link)
    );

    dcw_ctl i_ctl (
        .clk         (clk),
        .rst         (rst),
        .go          (go),
        .chain_en    (chain_en),
        .table_addr  (table_addr),
        .direct      (direct),
        .fetch_done  (fetch_done),
        .fetch_err   (fetch_err),
        .fetched     (fetched),
        .link        (link),
        .eng_done    (eng_done),
        .eng_err     (eng_err),
        .fetch_start (fetch_start),
        .fetch_base  (fetch_base),
        .eng_start   (eng_start),
        .exec        (exec),
        .busy        (busy),
        .err_sticky  (err_sticky),
        .evt         (evt)
    );

    dcw_irq i_irq (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .en  (irq_en),
        .irq (irq)
    );

    assign eng_rmt_addr = exec.rmt_addr;
    assign eng_loc_addr = exec.loc_addr;
    assign eng_nbytes   = exec.nbytes;
    assign eng_ctrl     = exec.ctrl;

endmodule

// File: tb/test_dma_chain_walker.sv
`timescale 1ns/1ps
module test_dma_chain_walker;

    localparam logic [31:0] BAD_COUNT = 32'h0000_BAD0;
    localparam logic [31:0] ERR_BASE  = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic        chain_en = 1'b0;
    logic        irq_en = 1'b0;
    logic [31:0] table_addr = '0;
    logic [31:0] dir_rmt_addr = '0;
    logic [31:0] dir_loc_addr = '0;
    logic [31:0] dir_nbytes = '0;
    logic [31:0] dir_ctrl = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        mem_err;
    logic        eng_start;
    logic [31:0] eng_rmt_addr, eng_loc_addr, eng_nbytes, eng_ctrl;
    logic        eng_done = 1'b0;
    logic        eng_err = 1'b0;
    logic        busy, err_sticky, irq;

    always #2.5 clk = ~clk;

    dma_chain_walker i_dma_chain_walker (
        .clk(clk), .rst(rst), .go(go), .chain_en(chain_en), .irq_en(irq_en),
        .table_addr(table_addr), .dir_rmt_addr(dir_rmt_addr),
        .dir_loc_addr(dir_loc_addr), .dir_nbytes(dir_nbytes), .dir_ctrl(dir_ctrl),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .mem_err(mem_err), .eng_start(eng_start),
        .eng_rmt_addr(eng_rmt_addr), .eng_loc_addr(eng_loc_addr),
        .eng_nbytes(eng_nbytes), .eng_ctrl(eng_ctrl), .eng_done(eng_done),
        .eng_err(eng_err), .busy(busy), .err_sticky(err_sticky), .irq(irq)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [31:0] mem [0:63];
    logic        ack_en = 1'b1;
    bit          stall_mode = 1'b0;
    logic [31:0] rd_log [0:63];
    int          nrd = 0;

    assign mem_ack   = mem_req & ack_en;
    assign mem_err   = mem_addr >= ERR_BASE;
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(negedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            if (nrd < 64) rd_log[nrd] = mem_addr;
            nrd++;
        end
        ack_en = stall_mode ? ~ack_en : 1'b1;
    end

    // ---------------- engine model ----------------
    logic [31:0] x_rmt [0:15];
    logic [31:0] x_loc [0:15];
    logic [31:0] x_cnt [0:15];
    logic [31:0] x_ctl [0:15];
    int          nx = 0;
    int          pend = 0;
    int          dbl_start = 0;
    int          drift = 0;
    int          wide_irq = 0;
    int          nirq = 0;
    logic        start_prev = 1'b0;
    logic        irq_prev = 1'b0;
    logic [31:0] cur_rmt, cur_loc, cur_cnt, cur_ctl;

    always @(negedge clk) begin
        eng_done = 1'b0;
        eng_err  = 1'b0;
        if (rst) begin
            pend = 0;
        end else begin
            if (eng_start && start_prev) dbl_start++;
            if (irq && irq_prev) wide_irq++;
            if (irq) nirq++;
            if (eng_start) begin
                cur_rmt = eng_rmt_addr; cur_loc = eng_loc_addr;
                cur_cnt = eng_nbytes;   cur_ctl = eng_ctrl;
                if (nx < 16) begin
                    x_rmt[nx] = cur_rmt; x_loc[nx] = cur_loc;
                    x_cnt[nx] = cur_cnt; x_ctl[nx] = cur_ctl;
                end
                nx++;
                pend = 3;
            end else if (pend > 0) begin
                if (eng_rmt_addr != cur_rmt || eng_loc_addr != cur_loc ||
                    eng_nbytes != cur_cnt || eng_ctrl != cur_ctl) drift++;
                pend--;
                if (pend == 0) begin
                    if (cur_cnt == BAD_COUNT) eng_err = 1'b1;
                    else eng_done = 1'b1;
                end
            end
        end
        start_prev = eng_start;
        irq_prev   = irq;
    end

    // ---------------- helpers ----------------
    function automatic logic [31:0] slot(int i);
        return 32'(32 * ((i * 3 + 1) % 8));
    endfunction

    function automatic logic [31:0] exp_rmt(int i); return 32'h1000_0000 + 32'(i * 32'h111); endfunction
    function automatic logic [31:0] exp_loc(int i); return 32'h2000_0040 + 32'(i * 8); endfunction

    // build a list of L entries; err_at >= 0 makes that entry fail in the engine;
    // bad_link makes entry 0 point into the failing memory region
    task automatic place(int L, int mask, int err_at, bit bad_link);
        for (int w = 0; w < 64; w++) mem[w] = '0;
        for (int i = 0; i < L; i++) begin
            int b = int'(slot(i)) / 4;
            mem[b + 0] = exp_rmt(i);
            mem[b + 1] = exp_loc(i);
            mem[b + 2] = (i == err_at) ? BAD_COUNT : 32'(i + 1);
            mem[b + 3] = 32'h0000_00A0 | 32'((mask >> i) & 1);
            if (i == 0 && bad_link) mem[b + 4] = ERR_BASE;
            else if (i == L - 1)    mem[b + 4] = 32'h0000_0041;
            else                    mem[b + 4] = slot(i + 1) | 32'h2;
        end
    endtask

    task automatic launch(bit chain, bit en, logic [31:0] tbl);
        int t = 0;
        nx = 0; nrd = 0; nirq = 0; dbl_start = 0; drift = 0; wide_irq = 0;
        @(negedge clk);
        chain_en = chain; irq_en = en; table_addr = tbl; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        while (busy && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 4000, "R4", "request did not finish", t, 4000);
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int popc(int v, int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += (v >> i) & 1;
        return c;
    endfunction

    task automatic run_chain(int L, int mask, int err_at, bit en);
        int  ex;
        int  exp_irq;
        bit  fld_ok = 1'b1;
        bit  adr_ok = 1'b1;
        place(L, mask, err_at, 1'b0);
        launch(1'b1, en, slot(0));
        ex = (err_at >= 0) ? err_at + 1 : L;
        chk(nx == ex, "R4", "transfer count", nx, ex);
        for (int i = 0; i < ex && i < nx; i++) begin
            logic [31:0] ecnt = (i == err_at) ? BAD_COUNT : 32'(i + 1);
            if (x_rmt[i] != exp_rmt(i) || x_loc[i] != exp_loc(i) || x_cnt[i] != ecnt ||
                x_ctl[i] != (32'h0000_00A0 | 32'((mask >> i) & 1))) fld_ok = 1'b0;
        end
        chk(fld_ok, "R3", "descriptor fields in list order", 0, 0);
        chk(nrd == 5 * ex, "R3", "read beat count", nrd, 5 * ex);
        for (int k = 0; k < 5 * ex && k < nrd; k++) begin
            if (rd_log[k] != slot(k / 5) + 32'(4 * (k % 5))) adr_ok = 1'b0;
        end
        chk(adr_ok, "R4", "descriptor read addresses", 0, 0);
        if (err_at >= 0) exp_irq = popc(mask, err_at) + 1;
        else             exp_irq = popc(mask, L - 1) + 1;
        if (!en) exp_irq = 0;
        chk(nirq == exp_irq, (err_at >= 0) ? "R8" : "R5", "irq pulse count", nirq, exp_irq);
        chk(err_sticky == (err_at >= 0), "R8", "error flag", err_sticky, err_at >= 0);
        chk(dbl_start == 0 && drift == 0, "R11", "start pulse or field drift",
            dbl_start + drift, 0);
        chk(wide_irq == 0, "R7", "irq wider than one cycle", wide_irq, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #1000000;
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        for (int w = 0; w < 64; w++) mem[w] = '0;
        repeat (4) @(negedge clk);
        chk(!busy && !mem_req && !eng_start && !irq && !err_sticky, "R1", "reset outputs",
            {busy, mem_req, eng_start, irq, err_sticky}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req && !irq, "R1", "idle after reset", {busy, mem_req, irq}, 0);

        // R2: direct transfer, both enables and both control bit values
        for (int v = 0; v < 4; v++) begin
            dir_rmt_addr = 32'hAB00_0000 + 32'(v);
            dir_loc_addr = 32'h00CD_0000 + 32'(v);
            dir_nbytes   = 32'(100 + v);
            dir_ctrl     = 32'(v & 1);
            launch(1'b0, v[1], 32'h0);
            chk(nx == 1, "R2", "direct transfer count", nx, 1);
            chk(x_rmt[0] == dir_rmt_addr && x_loc[0] == dir_loc_addr &&
                x_cnt[0] == dir_nbytes && x_ctl[0] == dir_ctrl, "R2", "direct fields",
                x_rmt[0], dir_rmt_addr);
            chk(nrd == 0, "R2", "no descriptor read", nrd, 0);
            chk(nirq == v[1], "R6", "direct completion irq", nirq, v[1]);
        end

        // R3 R4 R5 R6 R7: every list length 1..4, every per-entry mask, both enables,
        // with and without read stalls
        for (int st = 0; st < 2; st++) begin
            stall_mode = st[0];
            for (int L = 1; L <= 4; L++) begin
                for (int m = 0; m < (1 << L); m++) begin
                    run_chain(L, m, -1, 1'b1);
                    run_chain(L, m, -1, 1'b0);
                end
            end
        end
        stall_mode = 1'b0;

        // R8: engine failure at each position of a four-entry list
        for (int e = 0; e < 4; e++) begin
            run_chain(4, 4'b0101, e, 1'b1);
        end

        // R10: a good request after an error clears the flag
        run_chain(2, 0, 1, 1'b1);
        chk(err_sticky == 1'b1, "R10", "flag held after error", err_sticky, 1);
        run_chain(2, 0, -1, 1'b1);
        chk(err_sticky == 1'b0, "R10", "flag cleared by accepted go", err_sticky, 0);

        // R9: failing link read after the first entry
        place(2, 0, -1, 1'b1);
        launch(1'b1, 1'b1, slot(0));
        chk(nx == 1, "R9", "transfers before bad link", nx, 1);
        chk(nrd == 6, "R9", "reads stop at failing beat", nrd, 6);
        chk(err_sticky == 1'b1, "R9", "error flag", err_sticky, 1);
        chk(nirq == 1, "R9", "error irq", nirq, 1);

        // R9: failing read of the very first descriptor
        launch(1'b1, 1'b1, ERR_BASE);
        chk(nx == 0, "R9", "no transfer started", nx, 0);
        chk(nrd == 1, "R9", "single failed read", nrd, 1);
        chk(err_sticky == 1'b1 && nirq == 1, "R9", "flag and irq", {err_sticky, 8'(nirq)}, 1);

        // R10: go during a request is ignored
        place(2, 0, -1, 1'b0);
        nx = 0; nrd = 0; nirq = 0;
        @(negedge clk);
        chain_en = 1'b1; irq_en = 1'b1; table_addr = slot(0); go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        repeat (3) @(negedge clk);
        chain_en = 1'b0; dir_rmt_addr = 32'hFFFF_0000; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        for (int t = 0; t < 4000 && busy; t++) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(nx == 2, "R10", "ignored go transfer count", nx, 2);
        chk(x_rmt[0] == exp_rmt(0) && x_rmt[1] == exp_rmt(1), "R10",
            "ignored go fields", x_rmt[0], exp_rmt(0));
        chk(nirq == 1 && !busy, "R10", "single completion", nirq, 1);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule